// File: doc/BRIEF.md
# Debug and Bus Access Security Gate

This block decides once per reset whether the device runs secured, and it filters debug-port and external-bus traffic to match. At every reset it copies a nonvolatile option byte into a working option register. It then reads a two-bit security field from that copy and raises a secured status flag when the field holds the locking code.

While the device is secured, the debug port can reach only the most significant byte lane of the debug control/status registers. Any other debug access is refused: the target is never strobed, read data returns zero, and a one-cycle violation pulse follows. Instruction fetches over the external bus are always refused. External data accesses pass or fail according to a level bit that software controls.

An optional backdoor lets the CPU, running from internal memory, clear the secured state. It does this by writing a multi-byte key that matches a stored nonvolatile key. One wrong attempt locks the backdoor until the next reset.

Top module: `sec_access_gate`

## Requirements
- R1: While `rst` is high at a clock edge, `opt_q` loads `nv_opt`, and `secured_o` is set exactly when `nv_opt[1:0]` equals 2'b10.
- R2: The field codes 2'b00, 2'b01 and 2'b11 leave `secured_o` low after reset.
- R3: While secured, a debug access is forwarded (`dbg_fwd` high) only when `dbg_csr_hit` is 1 and `dbg_be` is exactly 4'b1000. The returned `dbg_rdata` then has its lower three bytes forced to zero.
- R4: A refused debug request keeps `dbg_fwd` low and returns `dbg_rdata` of zero. `dbg_viol` is high for one cycle after the clock edge that sampled the refused request, and it is low after an edge with no refused request.
- R5: While unsecured, every debug request is forwarded, and `dbg_rdata` equals `tgt_rdata` unmodified.
- R6: While secured, an external instruction fetch (`xb_fetch`=1) is never granted, whatever the value of `xb_lvl_block`.
- R7: While secured, an external data access (`xb_fetch`=0) is granted exactly when `xb_lvl_block` is 0. While unsecured, every external request is granted.
- R8: A key byte is taken only when `key_we`=1 and `key_src_cpu`=1. A debug-sourced write (`key_src_cpu`=0) does not advance the byte sequence.
- R9: After 8 accepted bytes, the first of which is compared with `nv_key[63:56]` and the last with `nv_key[7:0]`, a full match clears `secured_o` at the edge that takes the eighth byte. `secured_o` stays low until reset.
- R10: A mismatch on the eighth byte sets `key_locked`. While `key_locked` is set, no key sequence clears `secured_o`.
- R11: With the backdoor option disabled, key writes never clear `secured_o`, and `key_locked` stays low.
- R12: Reset clears `key_locked`, restarts the key sequence and reloads the secured state from `nv_opt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads the option byte |
| nv_opt | input | 8 | Nonvolatile option byte, security field in bits 1:0 |
| nv_key | input | 64 | Nonvolatile backdoor key, first byte in the top lane |
| opt_q | output | 8 | Working copy of the option byte |
| secured_o | output | 1 | Secured status flag seen by the debug port |
| dbg_req | input | 1 | Debug access request, read or write |
| dbg_csr_hit | input | 1 | Debug access targets a debug control/status register |
| dbg_be | input | 4 | Debug byte-lane enables |
| tgt_rdata | input | 32 | Read data from the addressed target |
| dbg_fwd | output | 1 | Request forwarded to the target |
| dbg_rdata | output | 32 | Filtered read data to the debug port |
| dbg_viol | output | 1 | One-cycle access-violation strobe |
| xb_req | input | 1 | External bus request |
| xb_fetch | input | 1 | External request is an instruction fetch |
| xb_lvl_block | input | 1 | Software level bit: block external data while secured |
| xb_grant | output | 1 | External request allowed |
| key_we | input | 1 | Backdoor key byte write strobe |
| key_src_cpu | input | 1 | Write comes from the CPU in internal memory (0: debug port) |
| key_byte | input | 8 | Key byte value |
| key_locked | output | 1 | Backdoor locked out after a failed attempt |

## Verification
On every cycle, the assertions check the gating relations. Fetch refusal and data gating by level follow the secured flag. Refused debug requests read zero and are followed by the violation pulse, which never appears without a cause. An unsecured gate forwards all debug requests. Once secured is low it stays low, and a locked-out secured device stays secured. Only the bench's scenarios can show the reset loading of each field code, the exact byte order of the key compare, and that debug-sourced key writes do not shift the sequence. The same holds for the lockout after a wrong key, its clearing by reset, and the behaviour with the backdoor disabled.

// File: rtl/sec_gate_pkg.sv
package sec_gate_pkg;
   localparam logic [1:0] SEC_CODE_LOCKED = 2'b10;

   function automatic logic field_is_secured(input logic [1:0] field);
      return field == SEC_CODE_LOCKED;
   endfunction
endpackage

// File: rtl/sec_opt_state.sv
module sec_opt_state #(
   parameter int OPT_W   = 8,
   parameter int SEC_LSB = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OPT_W-1:0] nv_opt,
   input  logic             unlock,
   output logic [OPT_W-1:0] opt_q,
   output logic             secured
);
   import sec_gate_pkg::*;

   always_ff @(posedge clk) begin
      if (rst) begin
         opt_q   <= nv_opt;
         secured <= field_is_secured(nv_opt[SEC_LSB +: 2]);
      end else if (unlock) begin
         secured <= 1'b0;
      end
   end
endmodule

// File: rtl/sec_key_seq.sv
module sec_key_seq #(
   parameter int KEY_BYTES = 8,
   localparam int KEY_W    = 8 * KEY_BYTES,
   localparam int CW       = $clog2(KEY_BYTES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             arm,
   input  logic             wr_en,
   input  logic             wr_src_cpu,
   input  logic [7:0]       wr_byte,
   input  logic [KEY_W-1:0] ref_key,
   output logic             unlock,
   output logic             locked
);
   logic [CW-1:0]      pos_q;
   logic [KEY_W-9:0]   hist_q;
   logic [KEY_W-1:0]   full;
   logic               take;
   logic               last;

   assign take = arm && wr_en && wr_src_cpu && !locked;
   assign last = pos_q == CW'(KEY_BYTES - 1);
   assign full = {hist_q, wr_byte};
   assign unlock = take && last && (full == ref_key);

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q  <= '0;
         hist_q <= '0;
         locked <= 1'b0;
      end else if (take) begin
         hist_q <= full[KEY_W-9:0];
         pos_q  <= last ? '0 : pos_q + 1'b1;
         if (last && (full != ref_key)) locked <= 1'b1;
      end
   end
endmodule

// File: rtl/sec_dbg_filter.sv
module sec_dbg_filter #(
   parameter int DATA_W  = 32,
   localparam int NB     = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              secured,
   input  logic              req,
   input  logic              csr_hit,
   input  logic [NB-1:0]     be,
   input  logic [DATA_W-1:0] tgt_rdata,
   output logic              fwd,
   output logic [DATA_W-1:0] rdata,
   output logic              viol
);
   localparam logic [NB-1:0]     UPPER_BE   = NB'(1) << (NB - 1);
   localparam logic [DATA_W-1:0] UPPER_MASK = {8'hFF, {(DATA_W-8){1'b0}}};

   logic allow;

   assign allow = !secured || (csr_hit && (be == UPPER_BE));
   assign fwd   = req && allow;

   always_comb begin
      rdata = '0;
      if (fwd) rdata = secured ? (tgt_rdata & UPPER_MASK) : tgt_rdata;
   end

   always_ff @(posedge clk) begin
      if (rst) viol <= 1'b0;
      else     viol <= req && !allow;
   end
endmodule

// File: rtl/sec_xbus_filter.sv
module sec_xbus_filter (
   input  logic secured,
   input  logic req,
   input  logic fetch,
   input  logic lvl_block,
   output logic grant
);
   always_comb begin
      if (!secured)   grant = req;
      else if (fetch) grant = 1'b0;
      else            grant = req && !lvl_block;
   end
endmodule

// File: rtl/sec_access_gate.sv
module sec_access_gate #(
   parameter int OPT_W       = 8,
   parameter int SEC_LSB     = 0,
   parameter int DATA_W      = 32,
   parameter int KEY_BYTES   = 8,
   parameter bit BACKDOOR_EN = 1'b1,
   localparam int NB         = DATA_W / 8,
   localparam int KEY_W      = 8 * KEY_BYTES
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [OPT_W-1:0]  nv_opt,
   input  logic [KEY_W-1:0]  nv_key,
   output logic [OPT_W-1:0]  opt_q,
   output logic              secured_o,
   input  logic              dbg_req,
   input  logic              dbg_csr_hit,
   input  logic [NB-1:0]     dbg_be,
   input  logic [DATA_W-1:0] tgt_rdata,
   output logic              dbg_fwd,
   output logic [DATA_W-1:0] dbg_rdata,
   output logic              dbg_viol,
   input  logic              xb_req,
   input  logic              xb_fetch,
   input  logic              xb_lvl_block,
   output logic              xb_grant,
   input  logic              key_we,
   input  logic              key_src_cpu,
   input  logic [7:0]        key_byte,
   output logic              key_locked
);
   if (SEC_LSB < 0 || SEC_LSB + 2 > OPT_W) begin : g_bad_field
      $error("security field lies outside the option byte");
   end
   if (DATA_W < 16 || DATA_W % 8 != 0) begin : g_bad_width
      $error("debug data width must be whole bytes, at least two");
   end
   if (KEY_BYTES < 2) begin : g_bad_key
      $error("backdoor key needs at least two bytes");
   end

   logic unlock;

   sec_opt_state #(.OPT_W(OPT_W), .SEC_LSB(SEC_LSB)) u_state (
      .clk     (clk),
      .rst     (rst),
      .nv_opt  (nv_opt),
      .unlock  (unlock),
      .opt_q   (opt_q),
      .secured (secured_o)
   );

   if (BACKDOOR_EN) begin : g_backdoor
      sec_key_seq #(.KEY_BYTES(KEY_BYTES)) u_key (
         .clk        (clk),
         .rst        (rst),
         .arm        (secured_o),
         .wr_en      (key_we),
         .wr_src_cpu (key_src_cpu),
         .wr_byte    (key_byte),
         .ref_key    (nv_key),
         .unlock     (unlock),
         .locked     (key_locked)
      );
   end else begin : g_no_backdoor
      logic unused_key_inputs;
      assign unused_key_inputs = ^{nv_key, key_we, key_src_cpu, key_byte};
      assign unlock     = 1'b0;
      assign key_locked = 1'b0;
   end

   sec_dbg_filter #(.DATA_W(DATA_W)) u_dbg (
      .clk       (clk),
      .rst       (rst),
      .secured   (secured_o),
      .req       (dbg_req),
      .csr_hit   (dbg_csr_hit),
      .be        (dbg_be),
      .tgt_rdata (tgt_rdata),
      .fwd       (dbg_fwd),
      .rdata     (dbg_rdata),
      .viol      (dbg_viol)
   );

   sec_xbus_filter u_xbus (
      .secured   (secured_o),
      .req       (xb_req),
      .fetch     (xb_fetch),
      .lvl_block (xb_lvl_block),
      .grant     (xb_grant)
   );
endmodule

// File: rtl/sec_gate_checker.sv
module sec_gate_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              secured_o,
   input logic              key_locked,
   input logic              dbg_req,
   input logic              dbg_fwd,
   input logic [DATA_W-1:0] dbg_rdata,
   input logic              dbg_viol,
   input logic              xb_req,
   input logic              xb_fetch,
   input logic              xb_lvl_block,
   input logic              xb_grant
);
   a_r6_fetch_refused: assert property (@(posedge clk) disable iff (rst)
      (secured_o && xb_req && xb_fetch) |-> !xb_grant);

   a_r7_data_by_level: assert property (@(posedge clk) disable iff (rst)
      (secured_o && xb_req && !xb_fetch) |-> (xb_grant == !xb_lvl_block));

   a_r4_refused_reads_zero: assert property (@(posedge clk) disable iff (rst)
      (dbg_req && !dbg_fwd) |-> (dbg_rdata == '0));

   a_r4_viol_follows: assert property (@(posedge clk) disable iff (rst)
      (dbg_req && !dbg_fwd) |=> dbg_viol);

   a_r4_viol_has_cause: assert property (@(posedge clk) disable iff (rst)
      (!dbg_req || dbg_fwd) |=> !dbg_viol);

   a_r5_open_forward: assert property (@(posedge clk) disable iff (rst)
      (!secured_o && dbg_req) |-> dbg_fwd);

   a_r9_no_resecure: assert property (@(posedge clk) disable iff (rst)
      !secured_o |=> !secured_o);

   a_r10_lock_holds: assert property (@(posedge clk) disable iff (rst)
      (key_locked && secured_o) |=> (key_locked && secured_o));
endmodule

bind sec_access_gate sec_gate_checker #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .secured_o    (secured_o),
   .key_locked   (key_locked),
   .dbg_req      (dbg_req),
   .dbg_fwd      (dbg_fwd),
   .dbg_rdata    (dbg_rdata),
   .dbg_viol     (dbg_viol),
   .xb_req       (xb_req),
   .xb_fetch     (xb_fetch),
   .xb_lvl_block (xb_lvl_block),
   .xb_grant     (xb_grant)
);

// File: tb/sec_access_gate_test.sv
module sec_access_gate_test;
   localparam logic [63:0] KEY = 64'h0123_4567_89AB_CDEF;
   localparam logic [31:0] TGT = 32'hA1B2_C3D4;
   // req csr be[3:0] xreq xfetch lvl | exp_fwd exp_grant exp_viol
   localparam int NV = 7;
   localparam logic [11:0] VEC [NV] = '{
      12'b1_1_1000_1_0_0_1_1_0,
      12'b1_1_1100_1_1_0_0_0_1,
      12'b1_0_1000_1_0_1_0_0_1,
      12'b1_0_1111_1_1_1_0_0_1,
      12'b0_0_0000_0_0_0_0_0_0,
      12'b1_1_0001_1_0_0_0_1_1,
      12'b0_1_1000_1_0_1_0_0_0
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [7:0]  nv_opt = 8'h02;
   logic        dbg_req = 0, dbg_csr_hit = 0, xb_req = 0, xb_fetch = 0, xb_lvl_block = 0;
   logic [3:0]  dbg_be = '0;
   logic        key_we = 0, key_src_cpu = 0;
   logic [7:0]  key_byte = '0;
   logic [7:0]  opt_q, opt_q_nb;
   logic        secured_o, dbg_fwd, dbg_viol, xb_grant, key_locked;
   logic [31:0] dbg_rdata, dbg_rdata_nb;
   logic        secured_nb, dbg_fwd_nb, dbg_viol_nb, xb_grant_nb, key_locked_nb;
   int n_vec = 0, n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   sec_access_gate uut (
      .clk(clk), .rst(rst), .nv_opt(nv_opt), .nv_key(KEY), .opt_q(opt_q),
      .secured_o(secured_o), .dbg_req(dbg_req), .dbg_csr_hit(dbg_csr_hit),
      .dbg_be(dbg_be), .tgt_rdata(TGT), .dbg_fwd(dbg_fwd), .dbg_rdata(dbg_rdata),
      .dbg_viol(dbg_viol), .xb_req(xb_req), .xb_fetch(xb_fetch),
      .xb_lvl_block(xb_lvl_block), .xb_grant(xb_grant), .key_we(key_we),
      .key_src_cpu(key_src_cpu), .key_byte(key_byte), .key_locked(key_locked));

   sec_access_gate #(.BACKDOOR_EN(1'b0)) uut_nb (
      .clk(clk), .rst(rst), .nv_opt(nv_opt), .nv_key(KEY), .opt_q(opt_q_nb),
      .secured_o(secured_nb), .dbg_req(dbg_req), .dbg_csr_hit(dbg_csr_hit),
      .dbg_be(dbg_be), .tgt_rdata(TGT), .dbg_fwd(dbg_fwd_nb), .dbg_rdata(dbg_rdata_nb),
      .dbg_viol(dbg_viol_nb), .xb_req(xb_req), .xb_fetch(xb_fetch),
      .xb_lvl_block(xb_lvl_block), .xb_grant(xb_grant_nb), .key_we(key_we),
      .key_src_cpu(key_src_cpu), .key_byte(key_byte), .key_locked(key_locked_nb));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [7:0] nv);
      @(negedge clk);
      rst = 1'b1; nv_opt = nv;
      @(negedge clk);
      rst = 1'b0;
      #5;
   endtask

   task automatic key_wr(input logic [7:0] b, input logic cpu);
      @(negedge clk);
      key_we = 1'b1; key_src_cpu = cpu; key_byte = b;
      @(negedge clk);
      key_we = 1'b0; key_src_cpu = 1'b0;
      #5;
   endtask

   task automatic key_all(input logic [63:0] k);
      for (int i = 0; i < 8; i++) key_wr(k[63 - 8*i -: 8], 1'b1);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset(8'h02);
      chk("R1 opt_q load", opt_q, 8'h02);
      chk("R1 secured on code 10", secured_o, 1);
      chk("R12 lock clear after reset", key_locked, 0);
      chk("R4 no viol after reset", dbg_viol, 0);

      // R3 R4 R6 R7 vector walk while secured
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         {dbg_req, dbg_csr_hit, dbg_be, xb_req, xb_fetch, xb_lvl_block} = VEC[v][11:3];
         #5;
         chk("R3 dbg_fwd", dbg_fwd, VEC[v][2]);
         chk("R3 R4 dbg_rdata", dbg_rdata, VEC[v][2] ? (TGT & 32'hFF00_0000) : 32'h0);
         chk("R6 R7 xb_grant", xb_grant, VEC[v][1]);
         #10;
         chk("R4 dbg_viol", dbg_viol, VEC[v][0]);
      end
      @(negedge clk);
      dbg_req = 0; xb_req = 0;
      #15;
      chk("R4 viol one cycle", dbg_viol, 0);

      // R2 the three unsecured codes
      do_reset(8'h00); chk("R2 code 00", secured_o, 0);
      do_reset(8'h01); chk("R2 code 01", secured_o, 0);
      do_reset(8'hF3); chk("R2 code 11", secured_o, 0);
      chk("R1 opt_q load F3", opt_q, 8'hF3);
      @(negedge clk);
      dbg_req = 1; dbg_csr_hit = 0; dbg_be = 4'hF; xb_req = 1; xb_fetch = 1; xb_lvl_block = 1;
      #5;
      chk("R5 open forward", dbg_fwd, 1);
      chk("R5 open rdata", dbg_rdata, TGT);
      chk("R7 open fetch grant", xb_grant, 1);
      #10;
      chk("R5 no viol when open", dbg_viol, 0);
      @(negedge clk);
      dbg_req = 0; xb_req = 0; xb_fetch = 0; xb_lvl_block = 0;

      // R8 R9 R11 unlock with an interleaved debug-sourced write
      do_reset(8'h02);
      for (int i = 0; i < 3; i++) key_wr(KEY[63 - 8*i -: 8], 1'b1);
      key_wr(8'h5A, 1'b0);
      for (int i = 3; i < 7; i++) key_wr(KEY[63 - 8*i -: 8], 1'b1);
      chk("R9 still secured after 7 bytes", secured_o, 1);
      key_wr(KEY[7:0], 1'b1);
      chk("R8 R9 unlocked by CPU key", secured_o, 0);
      chk("R9 no lock on match", key_locked, 0);
      chk("R11 backdoor disabled stays secured", secured_nb, 1);
      chk("R11 backdoor disabled no lock", key_locked_nb, 0);
      @(negedge clk);
      xb_req = 1; xb_fetch = 1;
      #5;
      chk("R9 fetch granted after unlock", xb_grant, 1);
      @(negedge clk);
      xb_req = 0; xb_fetch = 0;
      #5;
      chk("R9 stays unsecured", secured_o, 0);

      // R10 R12 mismatch lockout and its clearing
      do_reset(8'h02);
      chk("R12 reloaded secured", secured_o, 1);
      key_all(KEY ^ 64'h1);
      chk("R10 lock on mismatch", key_locked, 1);
      chk("R10 still secured", secured_o, 1);
      key_all(KEY);
      chk("R10 locked ignores good key", secured_o, 1);
      do_reset(8'h02);
      chk("R12 lock cleared", key_locked, 0);
      key_all(KEY);
      chk("R12 unlock after reset", secured_o, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule